// File: doc/BRIEF.md
# Hybrid Interrupt Coalescer

The coalescer sits between a device's completion source and its interrupt line. Each completion (a received frame, a finished storage command) arrives as a single-cycle strobe. Instead of one interrupt per completion, the block gathers completions into batches and raises one interrupt for each batch. A batch closes when either of two limits is met. The first limit is a programmable event count. The second is a programmable window, measured in clock cycles from the first event of the batch.

The timer runs only while a batch is open, so an idle device never interrupts the host. The interrupt stays high until the host acknowledges it. Completions that arrive while an interrupt is outstanding are never lost; they open the next batch. A batch-size output reports how many completions the signalled interrupt covers. The count threshold and the window length are sampled when a batch opens, so a change applies from the next batch on.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the interrupt output is low and the batch-size output is 0.
- R2: With a count threshold N of 2 or more, if the N-th event of a batch arrives in cycle t before the window ends, the interrupt is high from cycle t+1 and the batch size reads N.
- R3: The window opens at the batch's first event. For a first event in cycle t0, a window W and fewer than N events, the interrupt rises in cycle t0+W+1. The batch size counts every event in cycles t0 to t0+W inclusive, including a strobe in the expiry cycle.
- R4: With both limits active and no interrupt outstanding, the interrupt for a batch rises no later than W+1 cycles after the batch's first event.
- R5: While no event arrives and no batch is open, the interrupt output never rises.
- R6: A threshold of 0 or 1, or a window of 0, turns each event into its own interrupt one cycle later, with batch size 1, when no interrupt is outstanding.
- R7: The interrupt holds until ack is high in a cycle and falls in the next cycle. Events that arrive while it is high accumulate into the next batch. That batch, if its limit was already met, is signalled in the cycle after the interrupt falls.
- R8: The batch size saturates at 2^CNT_W-1 when a batch holds more events.
- R9: Threshold and window are sampled in the cycle of a batch's first event. Changes during an open batch do not affect it.
- R10: Under an event every cycle with a window W, a threshold that is never reached and immediate acks, interrupts rise every W+1 cycles, each with batch size W+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 1 | Completion strobe, one event per high cycle |
| cfg_cnt_i | input | CNT_W | Event-count threshold (0 behaves as 1) |
| cfg_win_i | input | WIN_W | Window length in cycles |
| ack_i | input | 1 | Host acknowledge of the outstanding interrupt |
| irq_o | output | 1 | Coalesced interrupt, level held until acknowledged |
| batch_o | output | CNT_W | Events in the most recently signalled batch |

## Verification
The bench sweeps every threshold from 0 to 6 against every window from 0 to 6, with event spacings of 1, 2 and 3 cycles. For each case it works out which limit closes the batch, the cycle the interrupt must rise in, and the batch size. A design that armed the timer at reset or on a free-running boundary, or that dropped the strobe landing in the expiry cycle, would be off by a cycle or by one event. Directed cases cover the following:
- Events arriving under an unacknowledged interrupt. A design that lost them, or re-signalled the old batch, shows a wrong second batch size.
- Overflow of the batch counter. Wrapping instead of saturating shows a small count.
- Configuration changed mid-batch. A design using live values fires early.
- Back-to-back traffic. A timer that restarts badly breaks the one-per-window cadence.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Default widths for the event counter and the window timer
  localparam int unsigned COAL_CNT_W = 6;
  localparam int unsigned COAL_WIN_W = 8;
endpackage

// File: rtl/coal_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset
module coal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/coal_evt_acc.sv
// Saturating accumulator of events in the open batch
module coal_evt_acc #(
  parameter int unsigned CNT_W = coal_pkg::COAL_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] tot_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] acc_q, acc_d;
  logic             acc_en;

  always_comb begin
    tot_o = acc_q;
    if (evt_i && (acc_q != CMAX)) tot_o = acc_q + CNT_W'(1);
    acc_d  = clr_i ? '0 : tot_o;
    acc_en = evt_i | clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/coal_win_tmr.sv
// Window timer armed by the first event of a batch
module coal_win_tmr #(
  parameter int unsigned WIN_W = coal_pkg::COAL_WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             active_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             expire_o
);
  logic [WIN_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = 1'b0;
    rem_d  = rem_q;
    if (start_i) begin
      rem_en = 1'b1;
      rem_d  = (win_i == '0) ? '0 : win_i - WIN_W'(1);
    end else if (active_i && (rem_q != '0)) begin
      rem_en = 1'b1;
      rem_d  = rem_q - WIN_W'(1);
    end
    expire_o = start_i ? (win_i == '0) : (active_i && (rem_q == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end
endmodule

// File: rtl/coal_trig_ctl.sv
// Batch state, threshold shadow, interrupt level and batch-size latch
module coal_trig_ctl #(
  parameter int unsigned CNT_W = coal_pkg::COAL_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] tot_i,
  input  logic             expire_i,
  output logic             active_o,
  output logic             start_o,
  output logic             fire_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] batch_o
);
  logic             act_q, act_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] bat_q;
  logic [CNT_W-1:0] thr_sel, thr_lim;
  logic             cnt_hit;

  always_comb begin
    start_o = evt_i & ~act_q;
    thr_sel = start_o ? cnt_i : thr_q;
    thr_lim = (thr_sel == '0) ? CNT_W'(1) : thr_sel;
    cnt_hit = (act_q | evt_i) & (tot_i >= thr_lim);
    // a met limit waits while the previous interrupt is outstanding
    fire_o  = (cnt_hit | expire_i) & ~irq_q;
    act_d   = ~fire_o & (act_q | evt_i);
    irq_d   = fire_o | (irq_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      act_q <= act_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       thr_q <= '0;
    else if (start_o) thr_q <= cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bat_q <= '0;
    else if (fire_o) bat_q <= tot_i;
  end

  assign active_o = act_q;
  assign irq_o    = irq_q;
  assign batch_o  = bat_q;
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int unsigned CNT_W = coal_pkg::COAL_CNT_W,
  parameter int unsigned WIN_W = coal_pkg::COAL_WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  input  logic [WIN_W-1:0] cfg_win_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] batch_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] tot;
  logic             expire;
  logic             batch_act;
  logic             start;
  logic             fire;

  coal_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  coal_evt_acc #(.CNT_W(CNT_W)) i_acc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt_i (evt_i),
    .clr_i (fire),
    .tot_o (tot)
  );

  coal_win_tmr #(.WIN_W(WIN_W)) i_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start),
    .active_i (batch_act),
    .win_i    (cfg_win_i),
    .expire_o (expire)
  );

  coal_trig_ctl #(.CNT_W(CNT_W)) i_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_i    (evt_i),
    .ack_i    (ack_i),
    .cnt_i    (cfg_cnt_i),
    .tot_i    (tot),
    .expire_i (expire),
    .active_o (batch_act),
    .start_o  (start),
    .fire_o   (fire),
    .irq_o    (irq_o),
    .batch_o  (batch_o)
  );
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk #(
  parameter int unsigned CNT_W = coal_pkg::COAL_CNT_W,
  parameter int unsigned WIN_W = coal_pkg::COAL_WIN_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_i,
  input logic             ack_i,
  input logic [CNT_W-1:0] cfg_cnt_i,
  input logic [WIN_W-1:0] cfg_win_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] batch_o,
  input logic             batch_act
);
  localparam logic [WIN_W:0] AGE_MAX = {(WIN_W+1){1'b1}};

  logic [WIN_W:0]   age_q;
  logic [WIN_W-1:0] win_sh;

  // cycles since the open batch's first event, and its sampled window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      win_sh <= '0;
    end else if (evt_i && !batch_act) begin
      age_q  <= (WIN_W+1)'(1);
      win_sh <= cfg_win_i;
    end else if (batch_act && (age_q != AGE_MAX)) begin
      age_q  <= age_q + (WIN_W+1)'(1);
    end
  end

  AST_BATCH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (batch_o != '0)); // R2

  AST_WINDOW_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_act && !irq_o && (age_q == {1'b0, win_sh})) |=> irq_o); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!batch_act && !evt_i && !irq_o) |=> !irq_o); // R5

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !batch_act && !irq_o && ((cfg_cnt_i <= CNT_W'(1)) || (cfg_win_i == '0)))
      |=> (irq_o && (batch_o == CNT_W'(1)))); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(batch_o))); // R7

  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o); // R7
endmodule

bind irq_coalescer irq_coalescer_chk #(.CNT_W(CNT_W), .WIN_W(WIN_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .evt_i     (evt_i),
  .ack_i     (ack_i),
  .cfg_cnt_i (cfg_cnt_i),
  .cfg_win_i (cfg_win_i),
  .irq_o     (irq_o),
  .batch_o   (batch_o),
  .batch_act (batch_act)
);

// File: tb/test_irq_coalescer.sv
`timescale 1ns/1ps
module test_irq_coalescer;
  localparam int CNT_W = 4;
  localparam int WIN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             evt_i;
  logic [CNT_W-1:0] cfg_cnt_i;
  logic [WIN_W-1:0] cfg_win_i;
  logic             ack_i;
  logic             irq_o;
  logic [CNT_W-1:0] batch_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  irq_coalescer #(.CNT_W(CNT_W), .WIN_W(WIN_W)) i_irq_coalescer (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .cfg_cnt_i (cfg_cnt_i),
    .cfg_win_i (cfg_win_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .batch_o   (batch_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs set at a falling edge, outputs seen at the next falling edge
  task automatic tick(input logic e, input logic a);
    evt_i = e;
    ack_i = a;
    @(negedge clk);
  endtask

  function automatic string trig_tag(input int nl, input int w, input int fc);
    if (nl == 1 || w == 0) return "R6";
    if (fc <= w) return "R2";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    evt_i = 1'b0;
    ack_i = 1'b0;
    cfg_cnt_i = '0;
    cfg_win_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 batch", int'(batch_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq after release", int'(irq_o), 0);
    chk("R1 batch after release", int'(batch_o), 0);

    // R5: idle line produces nothing
    cfg_cnt_i = 4'd3;
    cfg_win_i = 4'd2;
    for (int i = 0; i < 10; i++) begin
      tick(1'b0, 1'b0);
      chk("R5 idle", int'(irq_o), 0);
    end

    // sweep threshold x window x spacing
    for (int n = 0; n <= 6; n++) begin
      for (int w = 0; w <= 6; w++) begin
        for (int p = 1; p <= 3; p++) begin
          int nl, fc, f, exp_b;
          string tg;
          nl = (n == 0) ? 1 : n;
          fc = (nl - 1) * p;
          f  = (fc < w) ? fc : w;
          exp_b = f / p + 1;
          tg = trig_tag(nl, w, fc);
          cfg_cnt_i = CNT_W'(n);
          cfg_win_i = WIN_W'(w);
          for (int rel = 0; rel <= f; rel++) begin
            tick((rel % p) == 0, 1'b0);
            if (rel < f) chk("R4 early", int'(irq_o), 0);
          end
          chk("R4 rise cycle", int'(irq_o), 1);
          chk({tg, " batch"}, int'(batch_o), exp_b);
          tick(1'b0, 1'b1);
          chk("R7 release", int'(irq_o), 0);
          tick(1'b0, 1'b0);
          chk("R5 after batch", int'(irq_o), 0);
          tick(1'b0, 1'b0);
          chk("R5 after batch", int'(irq_o), 0);
        end
      end
    end

    // R7: events under an outstanding interrupt form the next batch
    cfg_cnt_i = 4'd3;
    cfg_win_i = 4'd15;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    chk("R7 first irq", int'(irq_o), 1);
    chk("R7 first batch", int'(batch_o), 3);
    for (int i = 0; i < 5; i++) begin
      tick(1'b1, 1'b0);
      chk("R7 hold", int'(irq_o), 1);
    end
    chk("R7 batch held", int'(batch_o), 3);
    tick(1'b0, 1'b1);
    chk("R7 drop", int'(irq_o), 0);
    tick(1'b0, 1'b0);
    chk("R7 second irq", int'(irq_o), 1);
    chk("R7 second batch", int'(batch_o), 5);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    chk("R7 idle", int'(irq_o), 0);

    // R8: saturation of the batch size
    cfg_cnt_i = 4'd1;
    cfg_win_i = 4'd15;
    tick(1'b1, 1'b0);
    chk("R8 setup irq", int'(irq_o), 1);
    cfg_cnt_i = 4'd15;
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    chk("R8 drop", int'(irq_o), 0);
    tick(1'b0, 1'b0);
    chk("R8 irq", int'(irq_o), 1);
    chk("R8 saturated batch", int'(batch_o), 15);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);

    // R9: configuration sampled at the first event
    cfg_cnt_i = 4'd4;
    cfg_win_i = 4'd10;
    tick(1'b1, 1'b0);
    cfg_cnt_i = 4'd1;
    cfg_win_i = 4'd0;
    for (int rel = 1; rel <= 9; rel++) begin
      tick((rel % 3) == 0, 1'b0);
      if (rel < 9) chk("R9 no early fire", int'(irq_o), 0);
    end
    chk("R9 irq", int'(irq_o), 1);
    chk("R9 batch", int'(batch_o), 4);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);

    // R10: one interrupt per W+1 cycles under saturating traffic
    cfg_cnt_i = 4'd15;
    cfg_win_i = 4'd3;
    for (int rel = 0; rel < 16; rel++) begin
      tick(1'b1, irq_o);
      chk("R10 cadence", int'(irq_o), ((rel % 4) == 3) ? 1 : 0);
      if ((rel % 4) == 3) chk("R10 batch", int'(batch_o), 4);
    end
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    chk("R10 idle", int'(irq_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule